// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral on a small register bus. The input clock is divided by an 8-bit programmable prescaler and then by a selectable post-divider of 16, 32, 64 or 128. Each divided tick lowers a 16-bit live count by one. When a tick arrives with the count at zero, the count reloads from a separate reload register and keeps running, so expiries repeat at a fixed period. Each expiry can produce a one-cycle interrupt pulse, a 128-cycle system reset request, or both, depending on two independent enable bits.

Software keeps the system alive by writing the count register before it expires. That write loads the new count at once and restarts the divider chain. Clearing the run bit freezes the whole chain. Software reads the run bit back to see whether the watchdog is active. After reset the block is armed with reset generation enabled and a long default period.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control reads 0x001B (run=1, reset-enable=1, interrupt-enable=0, divider select=3, prescale=0), reload and count both read 0x8000, and both outputs are low.
- R2: Address 0 is control, address 1 is reload and address 2 is the live count. Written values read back. Control bits 7:5 always read 0, and address 3 reads 0.
- R3: Control bits 15:8 hold P and bits 4:3 hold S. While running, the count falls by one every (P+1)*D input clocks, where S=0,1,2,3 gives D=16,32,64,128.
- R4: A write to the count register loads the value on that edge and restarts the divider chain. A write to control also restarts the chain.
- R5: A tick that arrives with the count at zero is an expiry: the count takes the reload value and counting continues. An expiry period is therefore (N+1)*(P+1)*D clocks.
- R6: With interrupt-enable (control bit 2) set, each expiry drives irq_o high for exactly one clock, starting at the expiry edge. With the bit clear, irq_o stays low.
- R7: With run (bit 0) and reset-enable (bit 1) set, an expiry drives rst_req_o high for exactly 128 clocks. With reset-enable clear, rst_req_o stays low.
- R8: With run clear, the count and the divider chain hold their values and no expiry occurs. The run bit reads back as written.
- R9: A write to the reload register does not change the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | One-cycle expiry interrupt |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
A divider counter that skips or repeats a state moves the expiry edge, and the bench sees this on irq_o on the exact clock where the period formula puts it. It also sees it in the count read back one tick after a restart. A wrong reload path shows up in the count read on the cycle after expiry. A wrong pulse-stretch counter shows up at the 128th or 129th clock of rst_req_o. The bench sweeps every divider select over several prescale and reload values, so a fault limited to one select value is seen within one period of at most a few thousand clocks.

// File: rtl/wd_pkg.sv
// Package: shared register layout and addresses for the watchdog.
// Assumes a 16-bit bus and the control layout given in the brief.
package wd_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_COUNT  = 2'd2;

    typedef struct packed {
        logic [7:0] pre_m1;
        logic [2:0] rsv;
        logic [1:0] div_sel;
        logic       irq_en;
        logic       rst_en;
        logic       run;
    } wd_ctrl_t;

    localparam wd_ctrl_t CTRL_RST = '{pre_m1: 8'd0, rsv: 3'd0, div_sel: 2'd3,
                                      irq_en: 1'b0, rst_en: 1'b1, run: 1'b1};
    localparam logic [DATA_W-1:0] COUNT_RST = 16'h8000;
endpackage

// File: rtl/wd_regs.sv
// Register file: holds control and reload, and muxes read data.
// Assumes the live count is held in the counter and passed in for reads.
module wd_regs
    import wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] live_count,
    output wd_ctrl_t          ctrl,
    output logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] rdata,
    output logic              ctrl_wr,
    output logic              count_wr
);
    logic reload_wr;

    // Decode the write strobes per register.
    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == ADR_CTRL);
        reload_wr = bus_wr && (bus_addr == ADR_RELOAD);
        count_wr  = bus_wr && (bus_addr == ADR_COUNT);
    end

    // Control register; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl     <= wd_ctrl_t'(bus_wdata);
            ctrl.rsv <= 3'd0;
        end
    end

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload <= COUNT_RST;
        else if (reload_wr) reload <= bus_wdata;
    end

    // Read mux.
    always_comb begin
        case (bus_addr)
            ADR_CTRL:   rdata = ctrl;
            ADR_RELOAD: rdata = reload;
            ADR_COUNT:  rdata = live_count;
            default:    rdata = '0;
        endcase
    end

    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl.rsv == 3'd0));
    a_r9_reload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_wr |=> $stable(reload));
endmodule

// File: rtl/wd_prescale.sv
// Divider chain: an 8-bit prescaler followed by a power-of-two post-divider.
// Assumes clr restarts both stages; a tick is one clock wide.
module wd_prescale #(
    parameter int PRE_W     = 8,
    parameter int POST_LOG0 = 4,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre_m1,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int POST_W = POST_LOG0 + (1 << SEL_W) - 1;

    logic [PRE_W-1:0]  pre_cnt;
    logic [POST_W-1:0] post_cnt;
    logic [POST_W-1:0] post_last;
    logic              pre_wrap;

    // Terminal value of the post-divider for the selected ratio.
    always_comb begin
        post_last = POST_W'((1 << (POST_LOG0 + int'(div_sel))) - 1);
    end

    assign pre_wrap = run && (pre_cnt == pre_m1);
    assign tick     = pre_wrap && (post_cnt == post_last) && !clr;

    // Advance the prescaler, and the post-divider on each prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt  <= '0;
            post_cnt <= (post_cnt >= post_last) ? '0 : post_cnt + 1'b1;
        end else if (run) begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end

    a_r8_chain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(pre_cnt) && $stable(post_cnt)));
    a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
    a_r4_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_cnt == '0 && post_cnt == '0));
endmodule

// File: rtl/wd_counter.sv
// Live down-counter: loads on a bus write, steps on a tick, reloads on expiry.
// Assumes tick is already gated by run; a load wins over a tick.
module wd_counter #(
    parameter int          CNT_W   = 16,
    parameter logic [15:0] RST_VAL = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    assign expire = tick && !load && (count == '0);

    // Update the live count.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= CNT_W'(RST_VAL);
        else if (load)   count <= load_val;
        else if (expire) count <= reload_val;
        else if (tick)   count <= count - 1'b1;
    end

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count != '0) |=> (count == $past(count) - 1'b1));
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(reload_val)));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));
endmodule

// File: rtl/wd_outputs.sv
// Output stage: one-cycle interrupt and a stretched reset request.
// Assumes expiries are at least 16 clocks apart.
module wd_outputs #(
    parameter int RST_HOLD = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic run,
    input  logic rst_en,
    input  logic irq_en,
    output logic irq_o,
    output logic rst_req_o
);
    localparam int HOLD_W = $clog2(RST_HOLD + 1);

    logic [HOLD_W-1:0] hold_cnt;
    logic              fire_rst;

    assign fire_rst  = expire && run && rst_en;
    assign rst_req_o = (hold_cnt != '0);

    // Register the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= expire && irq_en;
    end

    // Stretch the reset request over RST_HOLD clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_cnt <= '0;
        else if (fire_rst)       hold_cnt <= HOLD_W'(RST_HOLD);
        else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_en) |=> irq_o);
    a_r7_rst_start: assert property (@(posedge clk) disable iff (!rst_n)
        fire_rst |=> rst_req_o);
    a_r7_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req_o && !fire_rst) |=> !rst_req_o);
endmodule

// File: rtl/wdog_timer.sv
// Top: watchdog with register file, divider chain, counter and output stage.
// Assumes a synchronous active-low reset and a single clock domain.
module wdog_timer
    import wd_pkg::*;
#(
    parameter int RST_HOLD = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    wd_ctrl_t          ctrl;
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] count;
    logic              ctrl_wr;
    logic              count_wr;
    logic              tick;
    logic              expire;

    wd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .live_count(count), .ctrl(ctrl),
        .reload(reload), .rdata(bus_rdata), .ctrl_wr(ctrl_wr),
        .count_wr(count_wr)
    );

    wd_prescale #(.PRE_W(8), .POST_LOG0(4), .SEL_W(2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run),
        .clr(ctrl_wr || count_wr), .pre_m1(ctrl.pre_m1),
        .div_sel(ctrl.div_sel), .tick(tick)
    );

    wd_counter #(.CNT_W(DATA_W), .RST_VAL(COUNT_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(count_wr),
        .load_val(bus_wdata), .reload_val(reload), .count(count),
        .expire(expire)
    );

    wd_outputs #(.RST_HOLD(RST_HOLD)) u_out (
        .clk(clk), .rst_n(rst_n), .expire(expire), .run(ctrl.run),
        .rst_en(ctrl.rst_en), .irq_en(ctrl.irq_en), .irq_o(irq_o),
        .rst_req_o(rst_req_o)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !rst_req_o));
endmodule

// File: tb/sim_wdog_timer.sv
// Bench: sweeps prescale, divider select and reload, checking expiry edges.
module sim_wdog_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq_o;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;

    wdog_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .rst_req_o(rst_req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Write on the next rising edge; returns just after that edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Wait n edges then move to the following falling edge.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] mk_ctrl(int p, int s, bit irq, bit rst, bit run);
        return 16'((p << 8) | (s << 3) | (int'(irq) << 2) | (int'(rst) << 1) | int'(run));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check(v == 16'h001B, "R1 ctrl", v, 16'h001B);
        rd(2'd1, v); check(v == 16'h8000, "R1 reload", v, 16'h8000);
        rd(2'd2, v); check(v == 16'h8000, "R1 count", v, 16'h8000);
        check(!irq_o && !rst_req_o, "R1 outputs", {irq_o, rst_req_o}, 0);

        // R2 register map and reserved bits
        wr(2'd1, 16'h1234); @(negedge clk);
        rd(2'd1, v); check(v == 16'h1234, "R2 reload readback", v, 16'h1234);
        wr(2'd0, 16'h00E0); @(negedge clk);
        rd(2'd0, v); check(v == 16'h0000, "R2 reserved bits / R8 run readback", v, 0);
        rd(2'd3, v); check(v == 16'h0000, "R2 unused address", v, 0);

        // R8 frozen while stopped; R9 reload write leaves count alone
        wr(2'd2, 16'h0005); @(negedge clk);
        rd(2'd2, v); check(v == 16'h0005, "R4 immediate load", v, 5);
        edges(600);
        rd(2'd2, v); check(v == 16'h0005, "R8 count frozen", v, 5);
        check(!irq_o && !rst_req_o, "R8 no expiry", {irq_o, rst_req_o}, 0);
        wr(2'd1, 16'h0077); @(negedge clk);
        rd(2'd2, v); check(v == 16'h0005, "R9 count untouched", v, 5);

        // R3 R5 R6 R4 sweep over prescale, select and reload
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 4; s++) begin
                for (int n = 0; n < 3; n++) begin
                    int d;
                    int t;
                    d = 16 << s;
                    t = (n + 1) * (p + 1) * d;
                    wr(2'd0, mk_ctrl(p, s, 1'b1, 1'b0, 1'b1));
                    wr(2'd1, 16'(n));
                    wr(2'd2, 16'(n));
                    if (n > 0) begin
                        edges((p + 1) * d - 1);
                        rd(2'd2, v); check(v == 16'(n), "R3 before tick", v, n);
                        edges(1);
                        rd(2'd2, v); check(v == 16'(n - 1), "R3 one tick", v, n - 1);
                        edges(t - (p + 1) * d - 1);
                    end else begin
                        edges(t - 1);
                    end
                    rd(2'd2, v); check(v == 16'd0, "R5 at zero", v, 0);
                    check(!irq_o, "R6 no early irq", irq_o, 0);
                    edges(1);
                    check(irq_o, "R6 irq at expiry", irq_o, 1);
                    rd(2'd2, v); check(v == 16'(n), "R5 reloaded", v, n);
                    check(!rst_req_o, "R7 no reset when disabled", rst_req_o, 0);
                    edges(1);
                    check(!irq_o, "R6 irq one cycle", irq_o, 0);
                end
            end
        end

        // R7 reset pulse length, no interrupt
        wr(2'd0, mk_ctrl(0, 0, 1'b0, 1'b1, 1'b1));
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd1);
        edges(31);
        check(!rst_req_o, "R7 before expiry", rst_req_o, 0);
        edges(1);
        check(rst_req_o, "R7 pulse start", rst_req_o, 1);
        check(!irq_o, "R6 irq disabled", irq_o, 0);
        wr(2'd0, mk_ctrl(0, 0, 1'b0, 1'b1, 1'b0));
        edges(125);
        check(rst_req_o, "R7 pulse last cycle", rst_req_o, 1);
        edges(1);
        check(!rst_req_o, "R7 pulse ended", rst_req_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule